// File: doc/BRIEF.md
# Flash Status Register and Write Guard

This block keeps the status byte of a serial flash device and rules on every request that would change stored data or the status byte. The command decoder in front of it turns each completed instruction into a one-cycle strobe. The strobes are enable-writes, disable-writes, status write with a data byte, and program or erase with a kind code and a target address. The guard answers each status-write, program or erase strobe in the same cycle with exactly one of a grant or a deny. The array engine starts only on a grant. It pulses cycle-done when the internal cycle ends.

Permission comes from three sources. The first is an enable latch that must be set before each modifying request. The second is a three-bit protect level that shields a top-aligned region of the array. The third is a lock bit that, together with the active-low protect pin, freezes the protection fields. A busy flag stays set from each grant until cycle-done, and all requests are refused while it is set.

Top module: `flash_status_guard`

## Requirements
- R1: After reset the status byte reads 0x00.
- R2: Status layout: bit 0 busy, bit 1 enable latch, bits 4:2 protect level, bit 7 lock; bits 6:5 always read 0.
- R3: An enable strobe while not busy sets the enable latch, and a disable strobe while not busy clears it.
- R4: A status write, program or erase presented while the enable latch is 0 is denied, and the status byte keeps its other bits.
- R5: The enable latch reads 0 in the cycle after any status-write, program or erase strobe, whether it was granted or denied.
- R6: Kind codes are 0 page program, 1 sector erase, 2 block erase. For level 0 nothing is shielded. For level 7 every address is shielded. For a level L from 1 to 6, the addresses at or above 2^A − 2^(A−7+L) are shielded, where A is the address width. A request to a shielded address is denied.
- R7: Chip erase (kind code 3) is denied whenever the protect level is nonzero.
- R8: A granted status write loads the protect level from data bits 4:2 and the lock from data bit 7. It ignores data bits 6:5 and 1:0.
- R9: While the lock is 1 and the protect pin is low, a status write is denied and leaves bits 7 and 4:2 unchanged.
- R10: A grant sets busy, and cycle-done clears it. While busy, every request is denied and enable or disable strobes have no effect.
- R11: In a cycle with a status-write or program/erase strobe exactly one of grant and deny is high. In any other cycle both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wren_i | input | 1 | Enable-writes strobe |
| wrdi_i | input | 1 | Disable-writes strobe |
| srw_i | input | 1 | Status-write strobe |
| srw_data_i | input | 8 | Status-write data byte |
| op_req_i | input | 1 | Program or erase strobe |
| op_kind_i | input | 2 | 0 page program, 1 sector erase, 2 block erase, 3 chip erase |
| op_addr_i | input | ADDR_W | Target byte address |
| done_i | input | 1 | Internal cycle complete pulse |
| wp_n_i | input | 1 | Active-low protect pin |
| status_o | output | 8 | Status byte for readback |
| grant_o | output | 1 | Request accepted |
| deny_o | output | 1 | Request refused |

## Verification
The assertions assume the decoder raises at most one of the four strobes in any cycle. Under that assumption, the order in which the latch set and clear conditions are evaluated cannot be observed. They also assume cycle-done arrives only while a cycle is running or in a harmless idle cycle. The stimulus drives each strobe alone for one cycle, on the falling edge. It sends cycle-done only after the request has been resolved. The protect sweep uses an 8-bit address, so every address is tried against every level and every program and erase kind.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  typedef enum logic [1:0] {
    OP_PAGE_PROG   = 2'd0,
    OP_SECT_ERASE  = 2'd1,
    OP_BLK_ERASE   = 2'd2,
    OP_CHIP_ERASE  = 2'd3
  } op_kind_e;

  localparam int unsigned SB_BUSY  = 0;
  localparam int unsigned SB_WEL   = 1;
  localparam int unsigned SB_LVL   = 2;
  localparam int unsigned SB_LVL_W = 3;
  localparam int unsigned SB_LOCK  = 7;

  // True when addr falls in the shielded top region for level lvl.
  // Level L in 1..6 shields the top 2^(aw-7+L) bytes: the (7-L) high
  // address bits must all be ones.
  function automatic logic lvl_shields(input logic [31:0] addr,
                                       input int unsigned aw,
                                       input logic [2:0] lvl);
    int unsigned hi_bits;
    logic [31:0] head;
    logic [31:0] ones;
    if (lvl == 3'd0) return 1'b0;
    if (lvl == 3'd7) return 1'b1;
    hi_bits = 7 - int'(lvl);
    head    = addr >> (aw - hi_bits);
    ones    = (32'd1 << hi_bits) - 32'd1;
    return head == ones;
  endfunction

endpackage

// File: rtl/fsg_wel_latch.sv
module fsg_wel_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic wel_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     wel_o <= 1'b0;
    else if (clr_i) wel_o <= 1'b0;
    else if (set_i) wel_o <= 1'b1;
  end
endmodule

// File: rtl/fsg_status_core.sv
module fsg_status_core
  import fsg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                commit_i,
  input  logic [7:0]          data_i,
  input  logic                start_i,
  input  logic                done_i,
  output logic                busy_o,
  output logic [SB_LVL_W-1:0] lvl_o,
  output logic                lock_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_o  <= '0;
      lock_o <= 1'b0;
    end else if (commit_i) begin
      lvl_o  <= data_i[SB_LVL +: SB_LVL_W];
      lock_o <= data_i[SB_LOCK];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       busy_o <= 1'b0;
    else if (start_i) busy_o <= 1'b1;
    else if (done_i)  busy_o <= 1'b0;
  end
endmodule

// File: rtl/fsg_protect_decode.sv
module fsg_protect_decode
  import fsg_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [1:0]          kind_i,
  input  logic [SB_LVL_W-1:0] lvl_i,
  output logic                blocked_o
);
  logic [31:0] addr_ext;
  assign addr_ext = 32'(addr_i);

  always_comb begin
    if (op_kind_e'(kind_i) == OP_CHIP_ERASE) blocked_o = (lvl_i != '0);
    else blocked_o = lvl_shields(addr_ext, ADDR_W, lvl_i);
  end
endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard
  import fsg_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              srw_i,
  input  logic [7:0]        srw_data_i,
  input  logic              op_req_i,
  input  logic [1:0]        op_kind_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  input  logic              done_i,
  input  logic              wp_n_i,
  output logic [7:0]        status_o,
  output logic              grant_o,
  output logic              deny_o
);
  localparam int unsigned MIN_AW = 7;

  generate
    if (ADDR_W < MIN_AW || ADDR_W > 32) begin : g_bad_width
      initial $error("flash_status_guard: ADDR_W out of range");
    end
  endgenerate

  logic                wel;
  logic                busy;
  logic [SB_LVL_W-1:0] lvl;
  logic                lock;
  logic                blocked;

  // Named internal events
  logic any_req;
  logic hw_locked;
  logic op_ok;
  logic sr_ok;
  logic ev_grant;
  logic ev_wel_set;
  logic ev_wel_clr;
  logic ev_commit;

  assign any_req    = srw_i | op_req_i;
  assign hw_locked  = lock & ~wp_n_i;
  assign op_ok      = op_req_i & wel & ~busy & ~blocked;
  assign sr_ok      = srw_i & wel & ~busy & ~hw_locked;
  assign ev_grant   = op_ok | sr_ok;
  assign ev_commit  = sr_ok;
  assign ev_wel_set = wren_i & ~busy;
  assign ev_wel_clr = (wrdi_i & ~busy) | any_req;

  fsg_protect_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i    (op_addr_i),
    .kind_i    (op_kind_i),
    .lvl_i     (lvl),
    .blocked_o (blocked)
  );

  fsg_wel_latch u_wel (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (ev_wel_set),
    .clr_i (ev_wel_clr),
    .wel_o (wel)
  );

  fsg_status_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit_i (ev_commit),
    .data_i   (srw_data_i),
    .start_i  (ev_grant),
    .done_i   (done_i),
    .busy_o   (busy),
    .lvl_o    (lvl),
    .lock_o   (lock)
  );

  assign grant_o  = ev_grant;
  assign deny_o   = any_req & ~ev_grant;
  assign status_o = {lock, 2'b00, lvl, wel, busy};
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wren_i,
  input logic       wrdi_i,
  input logic       srw_i,
  input logic       op_req_i,
  input logic [1:0] op_kind_i,
  input logic       done_i,
  input logic       wp_n_i,
  input logic [7:0] status_o,
  input logic       grant_o,
  input logic       deny_o,
  input logic       hw_locked,
  input logic       ev_wel_clr
);
  logic any_req;
  assign any_req = srw_i | op_req_i;

  assert_single_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wren_i, wrdi_i, srw_i, op_req_i}));

  assert_answer_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |-> $countones({grant_o, deny_o}) == 1);

  assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !any_req |-> !grant_o && !deny_o);

  assert_spare_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[6:5] == 2'b00);

  assert_wren_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wren_i && !status_o[0] |=> status_o[1]);

  assert_wel_needed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |-> status_o[1]);

  assert_wel_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> !status_o[1]);

  assert_chip_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op_req_i && op_kind_i == 2'd3 && status_o[4:2] != 3'd0 |-> deny_o);

  assert_hw_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    srw_i && status_o[7] && !wp_n_i |=> $stable(status_o[7:2]));

  assert_hw_deny_R9: assert property (@(posedge clk) disable iff (!rst_n)
    srw_i && hw_locked |-> deny_o);

  assert_busy_refuse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[0] && any_req |-> deny_o);

  assert_grant_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |=> status_o[0]);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_i && !grant_o |=> !status_o[0]);

  assert_busy_keeps_wel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[0] && !any_req |=> $stable(status_o[1]));

  assert_clr_on_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |-> ev_wel_clr);
endmodule

bind flash_status_guard fsg_checker u_fsg_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .wren_i     (wren_i),
  .wrdi_i     (wrdi_i),
  .srw_i      (srw_i),
  .op_req_i   (op_req_i),
  .op_kind_i  (op_kind_i),
  .done_i     (done_i),
  .wp_n_i     (wp_n_i),
  .status_o   (status_o),
  .grant_o    (grant_o),
  .deny_o     (deny_o),
  .hw_locked  (hw_locked),
  .ev_wel_clr (ev_wel_clr)
);

// File: tb/test_flash_status_guard.sv
`timescale 1ns/1ps
module test_flash_status_guard;
  localparam int unsigned AW = 8;
  localparam int unsigned SPAN = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wren_i = 1'b0, wrdi_i = 1'b0, srw_i = 1'b0, op_req_i = 1'b0;
  logic [7:0]    srw_data_i = '0;
  logic [1:0]    op_kind_i = '0;
  logic [AW-1:0] op_addr_i = '0;
  logic          done_i = 1'b0, wp_n_i = 1'b1;
  logic [7:0]    status_o;
  logic          grant_o, deny_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  flash_status_guard #(.ADDR_W(AW)) i_flash_status_guard (
    .clk(clk), .rst_n(rst_n), .wren_i(wren_i), .wrdi_i(wrdi_i),
    .srw_i(srw_i), .srw_data_i(srw_data_i), .op_req_i(op_req_i),
    .op_kind_i(op_kind_i), .op_addr_i(op_addr_i), .done_i(done_i),
    .wp_n_i(wp_n_i), .status_o(status_o), .grant_o(grant_o), .deny_o(deny_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_wren();
    @(negedge clk) wren_i = 1'b1;
    @(negedge clk) wren_i = 1'b0;
  endtask

  task automatic pulse_wrdi();
    @(negedge clk) wrdi_i = 1'b1;
    @(negedge clk) wrdi_i = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk) done_i = 1'b1;
    @(negedge clk) done_i = 1'b0;
  endtask

  task automatic do_srw(input logic [7:0] d, output logic g, output logic n);
    @(negedge clk) begin srw_i = 1'b1; srw_data_i = d; end
    #1 begin g = grant_o; n = deny_o; end
    @(negedge clk) srw_i = 1'b0;
  endtask

  task automatic do_op(input logic [1:0] k, input logic [AW-1:0] a,
                       output logic g, output logic n);
    @(negedge clk) begin op_req_i = 1'b1; op_kind_i = k; op_addr_i = a; end
    #1 begin g = grant_o; n = deny_o; end
    @(negedge clk) op_req_i = 1'b0;
  endtask

  // Independent restatement of the shielded region
  function automatic bit shielded(input int lvl, input int addr);
    if (lvl == 0) return 1'b0;
    if (lvl == 7) return 1'b1;
    return addr >= int'(SPAN) - (int'(SPAN) >> (7 - lvl));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic g, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset status", status_o, 8'h00);
    check("R11 idle grant/deny", {grant_o, deny_o}, 0);

    // R4: no latch -> refused, nothing moves
    do_op(2'd0, 8'h00, g, n);
    check("R4 op without latch", {g, n}, 2'b01);
    check("R4 status after op", status_o, 8'h00);
    do_srw(8'hFF, g, n);
    check("R4 srw without latch", {g, n}, 2'b01);
    check("R4 status after srw", status_o, 8'h00);

    // R3 / R2: latch lifecycle and position
    pulse_wren();
    check("R3 R2 wren sets bit1", status_o, 8'h02);
    pulse_wrdi();
    check("R3 wrdi clears", status_o, 8'h00);

    // R8: granted write, ignored bits 6:5 and 1:0
    pulse_wren();
    do_srw(8'hE3, g, n);
    check("R8 srw granted", {g, n}, 2'b10);
    check("R8 R10 R5 status busy", status_o, 8'h81);

    // R10: busy refuses and ignores strobes
    pulse_wren();
    check("R10 wren ignored while busy", status_o, 8'h81);
    do_op(2'd0, 8'h00, g, n);
    check("R10 op refused while busy", {g, n}, 2'b01);
    pulse_done();
    check("R10 done clears busy", status_o, 8'h80);

    // R9: hardware lock
    wp_n_i = 1'b0;
    pulse_wren();
    check("R9 latch set before locked srw", status_o, 8'h82);
    do_srw(8'h1C, g, n);
    check("R9 locked srw denied", {g, n}, 2'b01);
    check("R9 R5 fields frozen, latch cleared", status_o, 8'h80);
    wp_n_i = 1'b1;
    pulse_wren();
    do_srw(8'h00, g, n);
    check("R9 pin high allows srw", {g, n}, 2'b10);
    pulse_done();
    check("R8 fields cleared", status_o, 8'h00);

    // R6 / R7 / R5 sweep
    for (int lvl = 0; lvl < 8; lvl++) begin
      pulse_wren();
      do_srw(8'(lvl << 2), g, n);
      check("R8 level write granted", {g, n}, 2'b10);
      pulse_done();
      check("R8 level loaded", status_o, lvl << 2);
      for (int k = 0; k < 3; k++) begin
        for (int a = 0; a < int'(SPAN); a++) begin
          pulse_wren();
          do_op(2'(k), AW'(a), g, n);
          if (shielded(lvl, a)) check("R6 shielded address", {g, n}, 2'b01);
          else                  check("R6 open address", {g, n}, 2'b10);
          check("R5 latch clear after op", status_o[1], 0);
          pulse_done();
        end
      end
      pulse_wren();
      do_op(2'd3, 8'h00, g, n);
      check("R7 chip erase", {g, n}, (lvl == 0) ? 2'b10 : 2'b01);
      pulse_done();
      check("R10 idle after sweep step", status_o, lvl << 2);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule